// File: doc/BRIEF.md
# Addressed Ring Transfer Stage

One node of a unidirectional packet ring. The stage sits between an upstream ring neighbour, a downstream ring neighbour and one local processing element. It routes each 80-bit packet by its 16-bit destination field. A packet that arrives from upstream is first captured. It is then either handed to the local element, when the destination matches the stage's own address, or sent on along the ring. The ring output carries both the packets that pass through and the packets the local element injects.

The stage is a single-clock synchronous pipeline with three one-packet steps: capture, forward decision and output. Every port pair uses a valid/ready handshake. A transfer happens on a rising edge when valid and ready are both high. Each stage in a ring gets a distinct address through a parameter.

Top module: `ring_stage`

## Requirements
- R1: Packet layout: bits 15:0 hold the destination, 31:16 the source, 47:32 the opcode and 79:48 the data. Only the destination is decoded, and every bit of a packet leaves the stage unchanged.
- R2: While `rst_n` is low, all three steps are empty: `dn_valid` and `loc_out_valid` are low, and `up_ready` and `loc_in_ready` are high.
- R3: A packet accepted from upstream whose destination equals `NODE_ADDR` appears on `loc_out_*` after the second rising edge following its acceptance. Such a packet never appears on the ring output.
- R4: A packet accepted from upstream with any other destination appears on `dn_*` after the third rising edge following its acceptance.
- R5: A locally injected packet accepted on `loc_in_*` appears on `dn_*` after the next rising edge.
- R6: When a pass-through packet in the forward step competes with a local injection for the output step, the pass-through packet wins. In that cycle `loc_in_ready` is low.
- R7: An output whose valid is high and whose ready is low holds its packet stable. No packet is lost or delivered twice under any backpressure.
- R8: Packets that take the same path (upstream to local, upstream to ring, local to ring) leave in the order they entered.
- R9: With all readies high, the stage accepts one upstream packet per cycle and delivers one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream packet valid |
| up_ready | output | 1 | Stage can take an upstream packet |
| up_pkt | input | 80 | Upstream packet |
| dn_valid | output | 1 | Ring output packet valid |
| dn_ready | input | 1 | Downstream can take the packet |
| dn_pkt | output | 80 | Ring output packet |
| loc_in_valid | input | 1 | Local injection valid |
| loc_in_ready | output | 1 | Stage accepts the injection |
| loc_in_pkt | input | 80 | Injected packet |
| loc_out_valid | output | 1 | Packet for the local element valid |
| loc_out_ready | input | 1 | Local element can take the packet |
| loc_out_pkt | output | 80 | Packet for the local element |

## Verification
The hardest case to reach is the priority collision. A pass-through packet must sit in the forward step at the same moment that an injection is valid and the output step has room. From the ports, this is only reached by timing an upstream packet exactly two edges ahead of the injection. A directed sequence builds this case and checks that the injection is stalled and then delivered next. Long random runs with high valid rates and random readies on both outputs then reach it many more times. Per-path queues check order, loss and duplication across those runs.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int PKT_W   = 80;
  localparam int ADDR_W  = 16;
  localparam int DST_LSB = 0;

  typedef logic [PKT_W-1:0]  pkt_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic addr_t dst_of(input pkt_t p);
    return p[DST_LSB +: ADDR_W];
  endfunction
endpackage

// File: rtl/ring_slot.sv
module ring_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic         load;
  logic [W-1:0] data_q;

  always_comb begin
    in_ready = !vld_q || out_ready;
    load     = in_valid && in_ready;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R2: reset leaves the step empty
  p_reset_empty_r2: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R7: a stalled packet stays put
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/ring_steer.sv
module ring_steer
  import ring_pkg::*;
(
  input  logic fwd_valid,
  output logic fwd_ready,
  input  logic fwd_local,
  input  pkt_t fwd_pkt,
  output logic loc_valid,
  input  logic loc_ready,
  input  logic inj_valid,
  output logic inj_ready,
  input  pkt_t inj_pkt,
  output logic arb_valid,
  input  logic arb_ready,
  output pkt_t arb_pkt
);
  logic pass_req;

  always_comb begin
    pass_req  = fwd_valid && !fwd_local;
    loc_valid = fwd_valid && fwd_local;
    fwd_ready = fwd_local ? loc_ready : arb_ready;
    // in-flight traffic first; injection only fills idle output slots
    arb_valid = pass_req || inj_valid;
    arb_pkt   = pass_req ? fwd_pkt : inj_pkt;
    inj_ready = arb_ready && !pass_req;
  end
endmodule

// File: rtl/ring_stage.sv
module ring_stage
  import ring_pkg::*;
#(
  parameter logic [15:0] NODE_ADDR = 16'h0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_valid,
  output logic        up_ready,
  input  logic [79:0] up_pkt,
  output logic        dn_valid,
  input  logic        dn_ready,
  output logic [79:0] dn_pkt,
  input  logic        loc_in_valid,
  output logic        loc_in_ready,
  input  logic [79:0] loc_in_pkt,
  output logic        loc_out_valid,
  input  logic        loc_out_ready,
  output logic [79:0] loc_out_pkt
);
  localparam int FW = PKT_W + 1;

  logic          cap_v, cap_rdy;
  pkt_t          cap_pkt;
  logic          cap_local;
  logic          fwd_v, fwd_rdy;
  logic [FW-1:0] fwd_word;
  logic          fwd_local;
  pkt_t          fwd_pkt;
  logic          arb_v, arb_rdy;
  pkt_t          arb_pkt;

  // step 1: capture
  ring_slot #(.W(PKT_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_valid(up_valid), .in_ready(up_ready), .in_data(up_pkt),
    .out_valid(cap_v), .out_ready(cap_rdy), .out_data(cap_pkt)
  );

  assign cap_local = (dst_of(cap_pkt) == NODE_ADDR);

  // step 2: forward decision, carries the route bit
  ring_slot #(.W(FW)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cap_v), .in_ready(cap_rdy), .in_data({cap_local, cap_pkt}),
    .out_valid(fwd_v), .out_ready(fwd_rdy), .out_data(fwd_word)
  );

  assign fwd_local = fwd_word[FW-1];
  assign fwd_pkt   = fwd_word[PKT_W-1:0];

  ring_steer u_steer (
    .fwd_valid(fwd_v), .fwd_ready(fwd_rdy), .fwd_local(fwd_local), .fwd_pkt(fwd_pkt),
    .loc_valid(loc_out_valid), .loc_ready(loc_out_ready),
    .inj_valid(loc_in_valid), .inj_ready(loc_in_ready), .inj_pkt(loc_in_pkt),
    .arb_valid(arb_v), .arb_ready(arb_rdy), .arb_pkt(arb_pkt)
  );

  assign loc_out_pkt = fwd_pkt;

  // step 3: ring output
  ring_slot #(.W(PKT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(arb_v), .in_ready(arb_rdy), .in_data(arb_pkt),
    .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_pkt)
  );

  // R3: only packets for this node reach the local element
  p_local_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_out_valid |-> dst_of(loc_out_pkt) == NODE_ADDR);

  // R5: an accepted injection is on the ring one edge later
  p_inject_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loc_in_valid && loc_in_ready |=> dn_valid && dn_pkt == $past(loc_in_pkt));

  // R6: a pass-through packet with room ahead takes the output step
  p_pass_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_v && !fwd_local && arb_rdy |=> dn_valid && dn_pkt == $past(fwd_pkt));
endmodule

// File: tb/test_ring_stage.sv
`timescale 1ns/100ps
module test_ring_stage;
  localparam logic [15:0] ADDR = 16'h0003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        up_valid, up_ready;
  logic [79:0] up_pkt;
  logic        dn_valid, dn_ready;
  logic [79:0] dn_pkt;
  logic        loc_in_valid, loc_in_ready;
  logic [79:0] loc_in_pkt;
  logic        loc_out_valid, loc_out_ready;
  logic [79:0] loc_out_pkt;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int seq   = 0;

  logic [79:0] q_loc[$];
  logic [79:0] q_pass[$];
  logic [79:0] q_inj[$];

  always #2.5 clk = ~clk;

  ring_stage #(.NODE_ADDR(ADDR)) i_ring_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_pkt(up_pkt),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_pkt(dn_pkt),
    .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_pkt(loc_in_pkt),
    .loc_out_valid(loc_out_valid), .loc_out_ready(loc_out_ready), .loc_out_pkt(loc_out_pkt)
  );

  function automatic logic [79:0] mk(input bit tag, input int s, input logic [15:0] op,
                                     input logic [15:0] src, input logic [15:0] dst);
    return {tag, s[30:0], op, src, dst};
  endfunction

  function automatic bit for_me(input logic [79:0] p);
    return p[15:0] == ADDR;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [79:0] pa [4];
    logic [79:0] p, p2;
    bit up_took, in_took;
    int dummy;
    dummy = $urandom(32'd4711);
    rst_n = 1'b0; up_valid = 0; up_pkt = '0; dn_ready = 0;
    loc_in_valid = 0; loc_in_pkt = '0; loc_out_ready = 0;
    cyc(); cyc();
    #1;
    // R2 reset state
    check("R2 dn_valid", 80'(dn_valid), 80'(0));
    check("R2 loc_out_valid", 80'(loc_out_valid), 80'(0));
    check("R2 up_ready", 80'(up_ready), 80'(1));
    check("R2 loc_in_ready", 80'(loc_in_ready), 80'(1));
    cyc();
    rst_n = 1'b1;
    cyc();

    // R3 local delivery after two edges, R1 fields intact
    p = mk(0, 11, 16'h00AB, 16'h0009, ADDR);
    up_valid = 1; up_pkt = p;
    #1 check("R3 up_ready", 80'(up_ready), 80'(1));
    cyc(); up_valid = 0;
    #1 check("R3 not yet", 80'(loc_out_valid), 80'(0));
    cyc();
    #1 check("R3 loc_out_valid", 80'(loc_out_valid), 80'(1));
    check("R1 R3 loc_out_pkt", loc_out_pkt, p);
    check("R3 not on ring", 80'(dn_valid), 80'(0));
    cyc();
    #1 check("R7 local hold", loc_out_pkt, p);
    loc_out_ready = 1;
    cyc();
    #1 check("R7 no duplicate local", 80'(loc_out_valid), 80'(0));

    // R4 pass-through after three edges
    p = mk(0, 12, 16'h1234, ADDR, 16'h0007);
    up_valid = 1; up_pkt = p;
    cyc(); up_valid = 0;
    #1 check("R4 edge1", 80'(dn_valid), 80'(0));
    cyc();
    #1 check("R4 edge2", 80'(dn_valid), 80'(0));
    check("R4 not local", 80'(loc_out_valid), 80'(0));
    cyc();
    #1 check("R4 dn_valid", 80'(dn_valid), 80'(1));
    check("R1 R4 dn_pkt", dn_pkt, p);
    dn_ready = 1;
    cyc();

    // R5 injection after one edge
    p = mk(1, 13, 16'h0042, ADDR, 16'h0001);
    dn_ready = 0; loc_in_valid = 1; loc_in_pkt = p;
    #1 check("R5 loc_in_ready", 80'(loc_in_ready), 80'(1));
    cyc(); loc_in_valid = 0;
    #1 check("R5 dn_pkt", dn_pkt, p);
    dn_ready = 1;
    cyc();

    // R6 collision: pass-through beats injection
    p  = mk(0, 14, 16'h0005, 16'h0002, 16'h0004);
    p2 = mk(1, 15, 16'h0006, ADDR, 16'h0002);
    up_valid = 1; up_pkt = p;
    cyc(); up_valid = 0;
    cyc();
    loc_in_valid = 1; loc_in_pkt = p2;
    #1 check("R6 injection stalled", 80'(loc_in_ready), 80'(0));
    cyc();
    #1 check("R6 pass first", dn_pkt, p);
    check("R6 injection now accepted", 80'(loc_in_ready), 80'(1));
    cyc(); loc_in_valid = 0;
    #1 check("R6 injection second", dn_pkt, p2);
    cyc();

    // R9 back-to-back throughput
    for (int i = 0; i < 4; i++) pa[i] = mk(0, 20 + i, 16'h0, 16'h0, 16'h0008);
    for (int i = 0; i < 8; i++) begin
      up_valid = (i < 4);
      if (i < 4) up_pkt = pa[i];
      #1;
      if (i < 4) check("R9 up_ready", 80'(up_ready), 80'(1));
      if (i >= 3 && i <= 6) check("R9 R8 stream", dn_pkt, pa[i-3]);
      cyc();
    end
    up_valid = 0;
    cyc();

    // random phase: R7 R8 with scoreboard queues
    up_took = 0; in_took = 0;
    for (int c = 0; c < 6000; c++) begin
      if (!up_valid || up_took) begin
        up_valid = ($urandom % 100) < 60;
        seq++;
        up_pkt = mk(0, seq, 16'($urandom), 16'($urandom),
                    ($urandom % 2) ? ADDR : 16'(($urandom % 5) + 4));
      end
      if (!loc_in_valid || in_took) begin
        loc_in_valid = ($urandom % 100) < 40;
        seq++;
        loc_in_pkt = mk(1, seq, 16'($urandom), ADDR, 16'(($urandom % 5) + 4));
      end
      dn_ready      = ($urandom % 100) < 70;
      loc_out_ready = ($urandom % 100) < 70;
      #1;
      up_took = up_valid && up_ready;
      in_took = loc_in_valid && loc_in_ready;
      if (up_took) begin
        if (for_me(up_pkt)) q_loc.push_back(up_pkt);
        else                q_pass.push_back(up_pkt);
      end
      if (in_took) q_inj.push_back(loc_in_pkt);
      if (loc_out_valid && loc_out_ready) begin
        if (q_loc.size() == 0) check("R7 R3 unexpected local", loc_out_pkt, 80'(0));
        else check("R8 local order", loc_out_pkt, q_loc.pop_front());
      end
      if (dn_valid && dn_ready) begin
        if (dn_pkt[79]) begin
          if (q_inj.size() == 0) check("R7 unexpected injected", dn_pkt, 80'(0));
          else check("R8 injected order", dn_pkt, q_inj.pop_front());
        end else begin
          if (q_pass.size() == 0) check("R7 unexpected pass", dn_pkt, 80'(0));
          else check("R8 pass order", dn_pkt, q_pass.pop_front());
        end
      end
      cyc();
    end

    // drain
    up_valid = 0; loc_in_valid = 0; dn_ready = 1; loc_out_ready = 1;
    for (int c = 0; c < 20; c++) begin
      #1;
      if (loc_out_valid) begin
        if (q_loc.size() == 0) check("R7 unexpected local", loc_out_pkt, 80'(0));
        else check("R8 local order", loc_out_pkt, q_loc.pop_front());
      end
      if (dn_valid) begin
        if (dn_pkt[79]) begin
          if (q_inj.size() == 0) check("R7 unexpected injected", dn_pkt, 80'(0));
          else check("R8 injected order", dn_pkt, q_inj.pop_front());
        end else begin
          if (q_pass.size() == 0) check("R7 unexpected pass", dn_pkt, 80'(0));
          else check("R8 pass order", dn_pkt, q_pass.pop_front());
        end
      end
      cyc();
    end
    check("R7 no local lost", 80'(q_loc.size()), 80'(0));
    check("R7 no pass lost", 80'(q_pass.size()), 80'(0));
    check("R7 no injection lost", 80'(q_inj.size()), 80'(0));

    done = 1;
    summary();
    $finish;
  end
endmodule